// File: doc/BRIEF.md
# PWM Duty Clamp

This block sits in the path between a PWM source that cannot be controlled and a load such as a motor driver. It caps the high time of each pulse that it forwards. The raw PWM input is brought into the system clock domain through a synchronizer. A counter starts at every synchronized rising edge, and the output follows the input until the counter reaches the permitted pulse width. If the input is still high at that point, the output drops and stays low until the next rising edge. Pulses that are short enough pass with their width unchanged. Both output edges lag the input by the same fixed latency.

The permitted width is the period in use multiplied by a duty fraction of 2^LIM_W, with the result rounded down. The period in use comes from an external period estimate. That estimate is smoothed by a first-order tracking filter, so the width limit follows slow drift and does not jump on every cycle. When no valid estimate is present, the block falls back to a default period parameter. The block samples the width limit at each rising edge and holds it for the whole of that pulse. A fraction of one or more disables truncation. A zero fraction keeps the output low.

Top module: `pwm_duty_clamp`

## Requirements
- R1: While reset is asserted, and after reset until a synchronized rising edge occurs, pwm_out is low.
- R2: A pulse that the input holds high for N clock cycles, with N no larger than the permitted width W, appears on pwm_out as exactly N high cycles. Both output edges lag the input by SYNC_STAGES+1 cycles (3 with two stages).
- R3: A pulse longer than W gives exactly W high output cycles. pwm_out then stays low until the next synchronized rising edge of the input.
- R4: W = floor(P × L / 2^LIM_W). L is duty_limit, read as an unsigned fraction of 2^LIM_W. P is the period in use at that rising edge.
- R5: If period_valid is low at a rising edge, P is DEF_PERIOD and the filter state is left unchanged.
- R6: If period_valid is high at a rising edge, the filter updates and P is the updated value. The first valid edge after reset, or after an invalid edge, loads period_est directly. Every later valid edge adds floor((period_est − F) / 2^FILT_SHIFT) to the filter value F.
- R7: If duty_limit is 2^LIM_W or more at a rising edge, that pulse passes for its whole high time without truncation.
- R8: If duty_limit is zero at a rising edge, pwm_out stays low for that whole pulse.
- R9: duty_limit, period_est and period_valid are sampled only at the rising edge. Changing them during a pulse does not change that pulse's output width.
- R10: An input held high for much longer than W produces one output pulse of W cycles and no second pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | Raw PWM from the external source, asynchronous to clk |
| period_est | input | CNT_W | Estimated input period, in clock cycles |
| period_valid | input | 1 | High when period_est can be used |
| duty_limit | input | LIM_W+1 | Maximum duty cycle as a fraction of 2^LIM_W |
| pwm_out | output | 1 | Clamped PWM sent to the load |

## Verification
The bench builds the block with 12-bit counters, an 8-bit duty fraction, two synchronizer stages, a default period of 100 cycles and a filter shift of 2. With these values every permitted width is a few tens of cycles. Boundary pulses of exactly W and W+1 cycles, and widths that round down to zero, therefore fit into short runs. The filter converges from 200 towards 40 in a few pulses, which brings the rounding of negative steps (floor of −22.5 gives −23) within reach.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
   localparam int unsigned PDC_MIN_SYNC = 2;

   typedef enum logic [1:0] {
      GATE_IDLE = 2'd0,
      GATE_PASS = 2'd1,
      GATE_CUT  = 2'd2
   } gate_st_e;
endpackage

// File: rtl/pdc_sync.sv
module pdc_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic lvl,
   output logic rise
);
   logic [STAGES-1:0] sh_q;
   logic              prev_q;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= din;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[STAGES-2:0], din};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sh_q[STAGES-1];
   end

   assign lvl  = sh_q[STAGES-1];
   assign rise = sh_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/pdc_width.sv
module pdc_width #(
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned LIM_W      = 8,
   parameter int unsigned DEF_PERIOD = 500,
   parameter int unsigned FILT_SHIFT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise,
   input  logic [CNT_W-1:0] period_est,
   input  logic             period_valid,
   input  logic [LIM_W:0]   duty_limit,
   output logic [CNT_W-1:0] w_next,
   output logic             byp_next
);
   localparam logic [CNT_W-1:0] DEF_P  = CNT_W'(DEF_PERIOD);
   localparam int unsigned      PROD_W = CNT_W + LIM_W;

   logic [CNT_W-1:0]  filt_next;
   logic [CNT_W-1:0]  period_use;
   logic [PROD_W-1:0] prod;

   generate
      if (FILT_SHIFT == 0) begin : g_direct
         assign filt_next = period_est;
      end else begin : g_track
         logic [CNT_W-1:0]  filt_q;
         logic              seeded_q;
         logic signed [CNT_W:0] diff;
         logic signed [CNT_W:0] step;
         logic signed [CNT_W:0] sum;

         assign diff = $signed({1'b0, period_est}) - $signed({1'b0, filt_q});
         assign step = diff >>> FILT_SHIFT;
         assign sum  = $signed({1'b0, filt_q}) + step;
         assign filt_next = seeded_q ? sum[CNT_W-1:0] : period_est;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               filt_q   <= DEF_P;
               seeded_q <= 1'b0;
            end else if (rise) begin
               if (period_valid) begin
                  filt_q   <= filt_next;
                  seeded_q <= 1'b1;
               end else begin
                  seeded_q <= 1'b0;
               end
            end
         end
      end
   endgenerate

   assign period_use = period_valid ? filt_next : DEF_P;
   assign prod       = {{LIM_W{1'b0}}, period_use} * {{CNT_W{1'b0}}, duty_limit[LIM_W-1:0]};
   assign w_next     = prod[PROD_W-1:LIM_W];
   assign byp_next   = duty_limit[LIM_W];
endmodule

// File: rtl/pdc_gate.sv
module pdc_gate
   import pdc_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lvl,
   input  logic             rise,
   input  logic [CNT_W-1:0] w_next,
   input  logic             byp_next,
   output logic [CNT_W-1:0] width_q,
   output logic             byp_q,
   output logic             pwm_out
);
   gate_st_e         st_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= GATE_IDLE;
         cnt_q   <= '0;
         width_q <= '0;
         byp_q   <= 1'b0;
      end else if (rise) begin
         width_q <= w_next;
         byp_q   <= byp_next;
         cnt_q   <= CNT_W'(1);
         st_q    <= (byp_next || (w_next != '0)) ? GATE_PASS : GATE_CUT;
      end else if (!lvl) begin
         st_q  <= GATE_IDLE;
         cnt_q <= '0;
      end else if (st_q == GATE_PASS) begin
         if (byp_q) begin
            st_q <= GATE_PASS;
         end else if (cnt_q < width_q) begin
            cnt_q <= cnt_q + 1'b1;
         end else begin
            st_q <= GATE_CUT;
         end
      end
   end

   assign pwm_out = (st_q == GATE_PASS);
endmodule

// File: rtl/pwm_duty_clamp.sv
module pwm_duty_clamp #(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned LIM_W       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DEF_PERIOD  = 500,
   parameter int unsigned FILT_SHIFT  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwm_in,
   input  logic [CNT_W-1:0] period_est,
   input  logic             period_valid,
   input  logic [LIM_W:0]   duty_limit,
   output logic             pwm_out
);
   if (SYNC_STAGES < pdc_pkg::PDC_MIN_SYNC) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (DEF_PERIOD >= (64'd1 << CNT_W)) begin : g_bad_def
      $error("DEF_PERIOD does not fit in CNT_W bits");
   end
   if (FILT_SHIFT >= CNT_W) begin : g_bad_filt
      $error("FILT_SHIFT must be below CNT_W");
   end
   if (LIM_W < 1) begin : g_bad_lim
      $error("LIM_W must be at least 1");
   end

   logic             lvl;
   logic             rise;
   logic [CNT_W-1:0] w_next;
   logic             byp_next;
   logic [CNT_W-1:0] width_q;
   logic             byp_q;

   pdc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (pwm_in),
      .lvl  (lvl),
      .rise (rise)
   );

   pdc_width #(
      .CNT_W     (CNT_W),
      .LIM_W     (LIM_W),
      .DEF_PERIOD(DEF_PERIOD),
      .FILT_SHIFT(FILT_SHIFT)
   ) u_width (
      .clk         (clk),
      .rst_n       (rst_n),
      .rise        (rise),
      .period_est  (period_est),
      .period_valid(period_valid),
      .duty_limit  (duty_limit),
      .w_next      (w_next),
      .byp_next    (byp_next)
   );

   pdc_gate #(.CNT_W(CNT_W)) u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl     (lvl),
      .rise    (rise),
      .w_next  (w_next),
      .byp_next(byp_next),
      .width_q (width_q),
      .byp_q   (byp_q),
      .pwm_out (pwm_out)
   );
endmodule

// File: rtl/pdc_chk.sv
module pdc_chk #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned LIM_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [LIM_W:0]   duty_limit,
   input logic             rise,
   input logic             lvl,
   input logic             pwm_out,
   input logic [CNT_W-1:0] width_q,
   input logic             byp_q
);
   logic [CNT_W:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             run_q <= '0;
      else if (!pwm_out)      run_q <= '0;
      else if (run_q != '1)   run_q <= run_q + 1'b1;
   end

   // R3
   run_within_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_out && !byp_q) |-> (run_q < {1'b0, width_q}));

   // R2
   out_needs_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_out |-> $past(lvl));

   // R3
   cut_stays_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwm_out && !rise) |=> !pwm_out);

   // R8
   zero_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && (duty_limit == '0)) |=> !pwm_out);

   // R7
   bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && duty_limit[LIM_W]) |=> pwm_out);
endmodule

bind pwm_duty_clamp pdc_chk #(.CNT_W(CNT_W), .LIM_W(LIM_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .duty_limit(duty_limit),
   .rise      (rise),
   .lvl       (lvl),
   .pwm_out   (pwm_out),
   .width_q   (width_q),
   .byp_q     (byp_q)
);

// File: tb/pwm_duty_clamp_test.sv
`timescale 1ns/1ps
module pwm_duty_clamp_test;
   localparam int CNT_W = 12;
   localparam int LIM_W = 8;
   localparam int DEFP  = 100;
   localparam int FSH   = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             pwm_in = 1'b0;
   logic [CNT_W-1:0] period_est = '0;
   logic             period_valid = 1'b0;
   logic [LIM_W:0]   duty_limit = 9'd128;
   logic             pwm_out;

   int    checks = 0;
   int    errors = 0;
   bit    done = 0;
   string phase = "R1";

   always #4 clk = ~clk;

   pwm_duty_clamp #(
      .CNT_W(CNT_W), .LIM_W(LIM_W), .SYNC_STAGES(2),
      .DEF_PERIOD(DEFP), .FILT_SHIFT(FSH)
   ) uut (
      .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .period_est(period_est),
      .period_valid(period_valid), .duty_limit(duty_limit), .pwm_out(pwm_out)
   );

   // reference model, updated at each rising clock edge
   int p1, p2, p3, m_cnt, m_w, m_filt, pu, nf, d;
   bit m_byp, m_seed, exp_out;

   always @(posedge clk) begin
      if (!rst_n) begin
         p1 = 0; p2 = 0; p3 = 0; m_cnt = 0; m_w = 0; m_byp = 0;
         m_filt = DEFP; m_seed = 0; exp_out = 0;
      end else begin
         if (p2 == 1 && p3 == 0) begin
            if (period_valid) begin
               if (FSH == 0 || !m_seed) nf = int'(period_est);
               else begin
                  d  = int'(period_est) - m_filt;
                  nf = m_filt + (d >>> FSH);
               end
               m_filt = nf; m_seed = 1; pu = nf;
            end else begin
               m_seed = 0; pu = DEFP;
            end
            m_byp = (int'(duty_limit) >= (1 << LIM_W));
            m_w   = m_byp ? 0 : (pu * int'(duty_limit)) / (1 << LIM_W);
            m_cnt = 1;
            exp_out = m_byp || (m_w > 0);
         end else if (p2 == 0) begin
            exp_out = 0;
         end else if (exp_out && !m_byp) begin
            if (m_cnt < m_w) m_cnt++;
            else exp_out = 0;
         end
         p3 = p2; p2 = p1; p1 = int'(pwm_in);
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (pwm_out !== exp_out) begin
            errors++;
            $display("FAIL %s cycle compare: pwm_out=%0b expected=%0b at %0t", phase, pwm_out, exp_out, $time);
         end
      end
   end

   task automatic check_val(input string req, input int act, input int expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // drive one pulse of hi cycles then lo low cycles, count output high cycles
   task automatic pulse(input string req, input int hi, input int lo, input int expw,
                        input int chg_at, input int new_lim);
      int cnt = 0;
      int first = -1;
      phase = req;
      for (int i = 0; i < hi + lo; i++) begin
         @(negedge clk);
         if (pwm_out) begin
            cnt++;
            if (first < 0) first = i;
         end
         if (i == chg_at) duty_limit = new_lim[LIM_W:0];
         pwm_in = (i < hi);
      end
      check_val(req, cnt, expw);
   endtask

   task automatic pulse_lat(input string req, input int hi, input int lo);
      int first = -1;
      int last = -1;
      phase = req;
      for (int i = 0; i < hi + lo; i++) begin
         @(negedge clk);
         if (pwm_out) begin
            if (first < 0) first = i;
            last = i;
         end
         pwm_in = (i < hi);
      end
      check_val({req, " rise latency"}, first, 3);
      check_val({req, " fall latency"}, last, hi + 2);
   endtask

   initial begin
      // R1: output low in reset and after it
      repeat (3) @(negedge clk);
      check_val("R1 in reset", int'(pwm_out), 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check_val("R1 after reset", int'(pwm_out), 0);

      // default period 100, limit 128 -> W=50 (R5)
      duty_limit = 9'd128; period_valid = 1'b0;
      pulse("R2", 30, 10, 30, -1, 0);
      pulse_lat("R2", 20, 10);
      pulse("R3", 80, 10, 50, -1, 0);
      pulse("R5", 50, 10, 50, -1, 0);
      // R4 boundary: limit 64 -> W=25
      duty_limit = 9'd64;
      pulse("R4 exact", 25, 10, 25, -1, 0);
      pulse("R4 plus one", 26, 10, 25, -1, 0);
      duty_limit = 9'd255;
      pulse("R4 limit255", 120, 10, 99, -1, 0);
      duty_limit = 9'd1;
      pulse("R4 rounds to zero", 40, 10, 0, -1, 0);

      // R6 filter: load 200, then track towards 40
      duty_limit = 9'd128; period_est = 12'd200; period_valid = 1'b1;
      pulse("R6 load", 150, 10, 100, -1, 0);
      period_est = 12'd40;
      pulse("R6 step1", 120, 10, 80, -1, 0);
      pulse("R6 step2", 120, 10, 65, -1, 0);
      pulse("R6 step3 floor", 120, 10, 53, -1, 0);
      period_valid = 1'b0;
      pulse("R5 fallback", 80, 10, 50, -1, 0);
      period_valid = 1'b1;
      pulse("R6 reload", 80, 10, 20, -1, 0);

      // R9: limit dropped mid-pulse has no effect on the current pulse
      pulse("R9", 60, 10, 20, 10, 0);
      // R8: zero limit
      duty_limit = 9'd0;
      pulse("R8", 50, 10, 0, -1, 0);
      // R7: bypass
      duty_limit = 9'd256;
      pulse("R7 full", 300, 10, 300, -1, 0);
      duty_limit = 9'd300;
      pulse("R7 above", 50, 10, 50, -1, 0);
      // R10: input held high a long time
      duty_limit = 9'd128; period_valid = 1'b0;
      pulse("R10", 1000, 10, 50, -1, 0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule